// File: doc/BRIEF.md
# Free-Running Timestamp Counter with Coherent Split Read

This block keeps a wide, free-running up-counter that serves as a time base. Software reads it through a narrow register port. The counter is wider than the data bus, so a full sample takes two reads.

The first read is of the low-word register, which returns the bottom bus-width bits. That same read copies the counter's upper bits into a shadow byte. A later read of the high register returns this shadow, so the two halves always belong to the same instant. The high register also carries the counter's run enable, and software writes it to start or stop counting.

Tick pacing comes from outside as a one-cycle strobe. The nominal rate is 983.04 kHz. The block raises no interrupt. Reads return data one cycle after the request, with a valid strobe.

Top module: `stb_timebase`

## Requirements
- R1: While `rst` is high and after it falls, the counter, the shadow byte and the enable are all zero. `bus_rvalid` and `bus_rdata` are zero during reset.
- R2: After reset the counter does not advance on ticks until software sets the enable.
- R3: While enabled, the counter increases by exactly one on each cycle with `tick` high, and keeps its value on cycles with `tick` low.
- R4: A read of offset `LO_OFS` (default 0x60) returns counter bits [DATA_W-1:0] on `bus_rdata`.
- R5: Each read of `LO_OFS` copies counter bits [CNT_W-1:DATA_W] into the shadow. The shadow changes at no other time, even when the counter carries into those bits.
- R6: When a tick and a low-word read fall in the same cycle, both the returned low word and the saved shadow come from the value before the increment.
- R7: A read of offset `HI_OFS` (default 0x64) returns the shadow in bits [CNT_W-DATA_W-1:0] and the enable in bit `EN_BIT` (default 8). All other bits read as zero.
- R8: A write to `HI_OFS` sets the enable from `bus_wdata[EN_BIT]` and leaves the shadow unchanged. Writes to any other offset have no effect. Reads of any other offset return zero.
- R9: The counter wraps from all ones to zero on the next enabled tick.
- R10: Clearing the enable holds the counter at its current value. Setting it again resumes counting from that value.
- R11: `bus_rvalid` is high in exactly the cycle after each cycle with `bus_rd` high, and `bus_rdata` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle count strobe |
| bus_rd | input | 1 | Read request for `bus_addr` |
| bus_wr | input | 1 | Write request for `bus_addr` |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_rd` |

## Verification
The bench builds the block with CNT_W=16, DATA_W=12 and ADDR_W=8, which leaves a 4-bit shadow. At these sizes a carry from the low word into the shadowed bits takes 4096 ticks, and a full wrap of the counter takes 65536 ticks. Both therefore fit in a short run, and the stale-shadow and wrap-around cases are exercised directly. EN_BIT stays at 8, so the enable sits at the same bit position as in the default build.

// File: rtl/stb_pkg.sv
package stb_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } sel_e;
endpackage

// File: rtl/stb_counter.sv
module stb_counter #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tick,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (en && tick)  cnt <= cnt + 1'b1;
  end

  // R1
  cnt_reset_chk: assert property (@(posedge clk) rst |=> (cnt == '0));
  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(en && tick) |=> $stable(cnt));
  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && tick) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/stb_ctrl.sv
module stb_ctrl #(
  parameter int HI_W   = 8,
  parameter int DATA_W = 32,
  parameter int EN_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lo_rd,
  input  logic              hi_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [HI_W-1:0]   cnt_hi,
  output logic [HI_W-1:0]   shadow,
  output logic              en
);
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      en     <= 1'b0;
    end else begin
      if (lo_rd) shadow <= cnt_hi;
      if (hi_wr) en     <= wdata[EN_BIT];
    end
  end

  // R5
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !lo_rd |=> $stable(shadow));
  // R8
  en_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !hi_wr |=> $stable(en));
endmodule

// File: rtl/stb_rdmux.sv
module stb_rdmux
  import stb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int HI_W   = 8,
  parameter int EN_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  sel_e              sel,
  input  logic [DATA_W-1:0] cnt_lo,
  input  logic [HI_W-1:0]   shadow,
  input  logic              en,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] hi_word;
  logic [DATA_W-1:0] nxt;

  always_comb begin
    hi_word             = '0;
    hi_word[HI_W-1:0]   = shadow;
    hi_word[EN_BIT]     = en;
  end

  always_comb begin
    unique case (sel)
      SEL_LO:  nxt = cnt_lo;
      SEL_HI:  nxt = hi_word;
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd;
      rdata  <= rd ? nxt : '0;
    end
  end

  // R11
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    rd |=> rvalid);
  // R11
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !rvalid);
endmodule

// File: rtl/stb_timebase.sv
module stb_timebase
  import stb_pkg::*;
#(
  parameter int                CNT_W  = 40,
  parameter int                DATA_W = 32,
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] LO_OFS = 'h60,
  parameter logic [ADDR_W-1:0] HI_OFS = 'h64,
  parameter int                EN_BIT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [CNT_W-1:0] cnt;
  logic [HI_W-1:0]  shadow;
  logic             en;
  logic             lo_rd;
  logic             hi_wr;
  sel_e             sel;

  always_comb begin
    sel = SEL_NONE;
    if (bus_addr == LO_OFS)      sel = SEL_LO;
    else if (bus_addr == HI_OFS) sel = SEL_HI;
  end

  assign lo_rd = bus_rd && (sel == SEL_LO);
  assign hi_wr = bus_wr && (sel == SEL_HI);

  stb_counter #(.W(CNT_W)) cnt_i (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .tick (tick),
    .cnt  (cnt)
  );

  stb_ctrl #(.HI_W(HI_W), .DATA_W(DATA_W), .EN_BIT(EN_BIT)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .lo_rd  (lo_rd),
    .hi_wr  (hi_wr),
    .wdata  (bus_wdata),
    .cnt_hi (cnt[CNT_W-1:DATA_W]),
    .shadow (shadow),
    .en     (en)
  );

  stb_rdmux #(.DATA_W(DATA_W), .HI_W(HI_W), .EN_BIT(EN_BIT)) rdmux_i (
    .clk    (clk),
    .rst    (rst),
    .rd     (bus_rd),
    .sel    (sel),
    .cnt_lo (cnt[DATA_W-1:0]),
    .shadow (shadow),
    .en     (en),
    .rdata  (bus_rdata),
    .rvalid (bus_rvalid)
  );

  // R6
  lo_pre_inc_chk: assert property (@(posedge clk) disable iff (rst)
    lo_rd |=> (bus_rdata == $past(cnt[DATA_W-1:0])));
  // R5
  shadow_capture_chk: assert property (@(posedge clk) disable iff (rst)
    lo_rd |=> (shadow == $past(cnt[CNT_W-1:DATA_W])));
endmodule

// File: tb/stb_timebase_tb_top.sv
module stb_timebase_tb_top;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 12;
  localparam int ADDR_W = 8;
  localparam int HI_W   = CNT_W - DATA_W;
  localparam logic [ADDR_W-1:0] LO = 8'h60;
  localparam logic [ADDR_W-1:0] HI = 8'h64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic bus_rd = 1'b0;
  logic bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic bus_rvalid;

  int n_run = 0;
  int n_fail = 0;

  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];

  logic [CNT_W-1:0] m_cnt = '0;
  logic [HI_W-1:0]  m_sh = '0;
  logic             m_en = 1'b0;

  always #2.5 clk = ~clk;

  stb_timebase #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                 .LO_OFS(LO), .HI_OFS(HI), .EN_BIT(8)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // driver: called at a negedge, drives one cycle, predicts, returns at the next negedge
  task automatic step(input logic tk, input logic rd, input logic wr,
                      input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                      input string tag);
    logic [DATA_W-1:0] e;
    tick = tk; bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    if (rd) begin
      e = '0;
      if (a == LO) e = m_cnt[DATA_W-1:0];
      else if (a == HI) begin
        e[HI_W-1:0] = m_sh;
        e[8] = m_en;
      end
      exp_q.push_back(e);
      tag_q.push_back(tag);
      if (a == LO) m_sh = m_cnt[CNT_W-1:DATA_W];
    end
    if (m_en && tk) m_cnt = m_cnt + 1'b1;
    if (wr && a == HI) m_en = wd[8];
    @(negedge clk);
    tick = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, '0, '0, "");
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        check("R11 unexpected rvalid", 32'(bus_rvalid), 32'd0);
      end else begin
        check(tag_q.pop_front(), 32'(bus_rdata), 32'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check("watchdog expired", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1: outputs idle in reset
    bus_rd = 1'b1; bus_addr = LO;
    repeat (3) @(negedge clk);
    check("R1 rvalid in reset", 32'(bus_rvalid), 32'd0);
    check("R1 rdata in reset", 32'(bus_rdata), 32'd0);
    bus_rd = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    step(1'b0, 1'b1, 1'b0, LO, '0, "R1 low after reset");
    step(1'b0, 1'b1, 1'b0, HI, '0, "R1 high after reset");
    idle(2);

    // R2: ticks ignored while enable is clear from reset
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 1'b0, '0, '0, "");
    step(1'b0, 1'b1, 1'b0, LO, '0, "R2 disabled after reset");
    idle(2);

    // R8/R7: set enable, read back enable in bit 8
    step(1'b0, 1'b0, 1'b1, HI, 12'h100, "");
    step(1'b0, 1'b1, 1'b0, HI, '0, "R7 enable readback");
    idle(2);

    // R3: intermittent tick pattern
    for (int i = 0; i < 21; i++) step((i % 3) == 0, 1'b0, 1'b0, '0, '0, "");
    step(1'b0, 1'b1, 1'b0, LO, '0, "R3 sparse ticks");
    for (int i = 0; i < 9; i++) step(1'b1, 1'b0, 1'b0, '0, '0, "");
    step(1'b0, 1'b1, 1'b0, LO, '0, "R3 dense ticks");

    // R11: latency of one cycle
    step(1'b0, 1'b1, 1'b0, LO, '0, "R11 read data");
    check("R11 rvalid next cycle", 32'(bus_rvalid), 32'd1);
    step(1'b0, 1'b0, 1'b0, '0, '0, "");
    check("R11 rvalid drops", 32'(bus_rvalid), 32'd0);

    // R6: tick and low read in the same cycle
    step(1'b1, 1'b1, 1'b0, LO, '0, "R6 pre-increment low");
    step(1'b0, 1'b1, 1'b0, LO, '0, "R6 post-increment low");
    idle(2);

    // R5: carry into upper bits leaves shadow stale until a low read
    while (m_cnt < 16'h1003) step(1'b1, 1'b0, 1'b0, '0, '0, "");
    step(1'b0, 1'b1, 1'b0, HI, '0, "R5 stale shadow");
    step(1'b0, 1'b1, 1'b0, LO, '0, "R4 low word after carry");
    step(1'b0, 1'b1, 1'b0, HI, '0, "R5 refreshed shadow");
    idle(2);

    // R8: low write ignored, unmapped read zero, high write keeps shadow
    step(1'b0, 1'b0, 1'b1, LO, 12'hABC, "");
    step(1'b0, 1'b1, 1'b0, LO, '0, "R8 low write ignored");
    step(1'b0, 1'b1, 1'b0, 8'h10, '0, "R8 unmapped read");
    step(1'b0, 1'b0, 1'b1, HI, 12'hEFF, "");
    step(1'b0, 1'b1, 1'b0, HI, '0, "R7 disabled readback other bits zero");

    // R10: disabled holds value, re-enable resumes
    for (int i = 0; i < 15; i++) step(1'b1, 1'b0, 1'b0, '0, '0, "");
    step(1'b0, 1'b1, 1'b0, LO, '0, "R10 held while disabled");
    step(1'b0, 1'b0, 1'b1, HI, 12'h100, "");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, '0, '0, "");
    step(1'b0, 1'b1, 1'b0, LO, '0, "R10 resumed");
    idle(2);

    // R9: wrap from all ones to zero
    while (m_cnt != 16'hFFFE) step(1'b1, 1'b0, 1'b0, '0, '0, "");
    step(1'b0, 1'b1, 1'b0, LO, '0, "R9 near top low");
    step(1'b0, 1'b1, 1'b0, HI, '0, "R9 near top high");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, '0, '0, "");
    step(1'b0, 1'b1, 1'b0, LO, '0, "R9 wrapped low");
    step(1'b0, 1'b1, 1'b0, HI, '0, "R9 wrapped high");
    idle(3);

    check("R11 all reads answered", 32'(exp_q.size()), 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule